// File: doc/BRIEF.md
# Refresh-Aware Bus Arbiter

This block decides who drives a processor subsystem's external bus. Two internal masters, a CPU and a DMA controller, compete for bus cycles. A DRAM refresh timer raises refresh demands. A single external device can ask for the whole bus through an active-low hold request and is answered through an active-low hold acknowledge. The block grants one bus cycle at a time and re-arbitrates only between cycles. The order of preference is external device, then a pending refresh, then DMA, then CPU. When it hands the bus to the external device, it first parks the strobes at their inactive level for one cycle. It then lowers the pin drive enable and pulls the acknowledge low.

If a refresh becomes due while the external device holds the bus, the acknowledge is raised again as a hint. The bus is still left with the external device until its request goes inactive. The arbiter then runs the refresh before any CPU or DMA cycle. A refresh demand that lands exactly as the bus is being handed over can keep the acknowledge from ever going low. The bus is released all the same.

The controller has six states:
- ST_IDLE: the CPU is the default owner and no grant is active.
- ST_CPU and ST_DMA: one internal bus cycle is granted.
- ST_REFRESH: the refresh is granted.
- ST_PARK: the strobes are driven inactive before the hand-over.
- ST_RELEASED: the pins are undriven.

It has these transitions:
- IDLE→PARK on a synchronized external request.
- IDLE→REFRESH, IDLE→DMA and IDLE→CPU by priority.
- CPU/DMA→IDLE on cycle done.
- REFRESH→IDLE on refresh done.
- PARK→RELEASED unconditionally.
- RELEASED→REFRESH or RELEASED→IDLE when the synchronized request drops, depending on whether a refresh is pending.

Top module: `refresh_bus_arbiter`

## Requirements
- R1: During and after reset the state is idle, every grant is 0, `ext_hold_ack_n` is 1, `pin_drive_en` is 1, `strobe_park` is 0 and no refresh is pending.
- R2: From idle, the next owner is chosen in this order: synchronized external request, then a pending refresh, then `dma_req`, then `cpu_req`. At most one of cpu_gnt, dma_gnt and rfsh_gnt is 1, and none of them is 1 while the pins are released.
- R3: A CPU or DMA grant stays 1 until `cyc_done` is sampled 1. The arbiter then returns to idle for one cycle before the next grant.
- R4: `ext_hold_req_n` passes through two synchronizing flops. A low level first sampled at clock edge k moves an idle arbiter into the park state at edge k+2.
- R5: The hand-over is one cycle with `strobe_park`=1 and `pin_drive_en`=1. It is followed by `pin_drive_en`=0, with `ext_hold_ack_n`=0 unless a refresh is pending or requested.
- R6: A DMA controller that requests continuously (a burst) loses the bus to a pending external request at the next cycle boundary.
- R7: A refresh request sampled while released sets `ext_hold_ack_n` to 1 at the next edge. `pin_drive_en` stays 0 while the synchronized external request stays low.
- R8: When the synchronized external request goes inactive, the arbiter leaves the released state. If a refresh is pending it goes directly to the refresh grant, ahead of any CPU or DMA grant. Otherwise it goes to idle.
- R9: A refresh request sampled in the park cycle keeps `ext_hold_ack_n` at 1 throughout the release. The pins are released anyway.
- R10: A refresh request is remembered until `rfsh_done` is sampled 1 while `rfsh_gnt` is 1. A `rfsh_done` at any other time has no effect.
- R11: `ext_hold_ack_n` is a register output. It is 0 only while `pin_drive_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_hold_req_n | input | 1 | External bus request, active low, asynchronous |
| ext_hold_ack_n | output | 1 | External bus acknowledge, active low, registered |
| cpu_req | input | 1 | CPU wants a bus cycle |
| cpu_gnt | output | 1 | CPU bus cycle granted |
| dma_req | input | 1 | DMA controller wants a bus cycle |
| dma_gnt | output | 1 | DMA bus cycle granted |
| cyc_done | input | 1 | Current CPU/DMA bus cycle ends this clock |
| rfsh_req | input | 1 | Refresh demand pulse from the interval timer |
| rfsh_gnt | output | 1 | Refresh cycle granted to the DRAM controller |
| rfsh_done | input | 1 | Refresh cycle complete |
| pin_drive_en | output | 1 | 1: address, data and strobe pins driven; 0: high impedance |
| strobe_park | output | 1 | Force strobes to their inactive high level |

## Verification
Grants, `pin_drive_en` and `strobe_park` follow the state register, so they change at the first edge after the input that causes them. `ext_hold_ack_n` is registered from the next state and lands on that same edge. A change on `ext_hold_req_n` takes two extra edges for synchronization: the park state appears at the third edge after the request is driven and the low acknowledge at the fourth. The bench drives inputs on falling edges. A behavioural model steps once per rising edge and is compared against every output on the following falling edge, so each expected value is sampled exactly one edge after the cause that the model accounts for.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CPU      = 3'd1,
        ST_DMA      = 3'd2,
        ST_REFRESH  = 3'd3,
        ST_PARK     = 3'd4,
        ST_RELEASED = 3'd5
    } arb_state_e;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RESET_VAL;
        else        chain[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= RESET_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/arb_refresh_track.sv
module arb_refresh_track (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_req,
    input  logic rfsh_done,
    input  logic in_refresh,
    output logic pending
);
    logic pend_q;
    logic clear;

    assign clear = rfsh_done & in_refresh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= rfsh_req | (pend_q & ~clear);
    end

    assign pending = pend_q;
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_req,
    input  logic       rfsh_pending,
    input  logic       rfsh_req,
    input  logic       rfsh_done,
    input  logic       cpu_req,
    input  logic       dma_req,
    input  logic       cyc_done,
    output arb_state_e state,
    output logic       ack_n,
    output logic       cpu_gnt,
    output logic       dma_gnt,
    output logic       rfsh_gnt,
    output logic       pin_drive_en,
    output logic       strobe_park
);
    arb_state_e state_q, state_d;
    logic       ack_n_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ext_req)           state_d = ST_PARK;
                else if (rfsh_pending) state_d = ST_REFRESH;
                else if (dma_req)      state_d = ST_DMA;
                else if (cpu_req)      state_d = ST_CPU;
                else                   state_d = ST_IDLE;
            end
            ST_CPU:      if (cyc_done)  state_d = ST_IDLE;
            ST_DMA:      if (cyc_done)  state_d = ST_IDLE;
            ST_REFRESH:  if (rfsh_done) state_d = ST_IDLE;
            ST_PARK:                    state_d = ST_RELEASED;
            ST_RELEASED: begin
                if (!ext_req)
                    state_d = rfsh_pending ? ST_REFRESH : ST_IDLE;
            end
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_n_q <= 1'b1;
        end else begin
            state_q <= state_d;
            ack_n_q <= ~((state_d == ST_RELEASED) & ~rfsh_pending & ~rfsh_req);
        end
    end

    always_comb begin
        cpu_gnt      = 1'b0;
        dma_gnt      = 1'b0;
        rfsh_gnt     = 1'b0;
        pin_drive_en = 1'b1;
        strobe_park  = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_CPU:      cpu_gnt      = 1'b1;
            ST_DMA:      dma_gnt      = 1'b1;
            ST_REFRESH:  rfsh_gnt     = 1'b1;
            ST_PARK:     strobe_park  = 1'b1;
            ST_RELEASED: pin_drive_en = 1'b0;
            default:     ;
        endcase
    end

    assign state = state_q;
    assign ack_n = ack_n_q;
endmodule

// File: rtl/refresh_bus_arbiter.sv
module refresh_bus_arbiter
    import arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_hold_req_n,
    output logic ext_hold_ack_n,
    input  logic cpu_req,
    output logic cpu_gnt,
    input  logic dma_req,
    output logic dma_gnt,
    input  logic cyc_done,
    input  logic rfsh_req,
    output logic rfsh_gnt,
    input  logic rfsh_done,
    output logic pin_drive_en,
    output logic strobe_park
);
    logic       req_n_sync;
    logic       ext_req;
    logic       pending;
    arb_state_e state;

    arb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_hold_req_n),
        .q     (req_n_sync)
    );

    assign ext_req = ~req_n_sync;

    arb_refresh_track u_rfsh (
        .clk        (clk),
        .rst_n      (rst_n),
        .rfsh_req   (rfsh_req),
        .rfsh_done  (rfsh_done),
        .in_refresh (state == ST_REFRESH),
        .pending    (pending)
    );

    arb_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_req      (ext_req),
        .rfsh_pending (pending),
        .rfsh_req     (rfsh_req),
        .rfsh_done    (rfsh_done),
        .cpu_req      (cpu_req),
        .dma_req      (dma_req),
        .cyc_done     (cyc_done),
        .state        (state),
        .ack_n        (ext_hold_ack_n),
        .cpu_gnt      (cpu_gnt),
        .dma_gnt      (dma_gnt),
        .rfsh_gnt     (rfsh_gnt),
        .pin_drive_en (pin_drive_en),
        .strobe_park  (strobe_park)
    );
endmodule

// File: rtl/refresh_bus_arbiter_chk.sv
module refresh_bus_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_hold_ack_n,
    input logic cpu_gnt,
    input logic dma_gnt,
    input logic rfsh_gnt,
    input logic cyc_done,
    input logic rfsh_req,
    input logic rfsh_done,
    input logic pin_drive_en,
    input logic strobe_park
);
    p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_gnt, dma_gnt, rfsh_gnt, ~pin_drive_en}));

    p_cpu_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && !cyc_done) |=> cpu_gnt);

    p_dma_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt && !cyc_done) |=> dma_gnt);

    p_park_to_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_park |=> !pin_drive_en);

    p_refresh_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_req |=> ext_hold_ack_n);

    p_refresh_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_gnt && !rfsh_done) |=> rfsh_gnt);

    p_ack_only_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_hold_ack_n |-> !pin_drive_en);
endmodule

bind refresh_bus_arbiter refresh_bus_arbiter_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ext_hold_ack_n (ext_hold_ack_n),
    .cpu_gnt        (cpu_gnt),
    .dma_gnt        (dma_gnt),
    .rfsh_gnt       (rfsh_gnt),
    .cyc_done       (cyc_done),
    .rfsh_req       (rfsh_req),
    .rfsh_done      (rfsh_done),
    .pin_drive_en   (pin_drive_en),
    .strobe_park    (strobe_park)
);

// File: tb/refresh_bus_arbiter_test.sv
module refresh_bus_arbiter_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_hold_req_n = 1'b1;
    logic cpu_req = 1'b0, dma_req = 1'b0, cyc_done = 1'b0;
    logic rfsh_req = 1'b0, rfsh_done = 1'b0;
    logic ext_hold_ack_n, cpu_gnt, dma_gnt, rfsh_gnt, pin_drive_en, strobe_park;

    int n_cmp = 0;
    int n_bad = 0;
    bit force_done = 1'b0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_bus_arbiter uut (
        .clk(clk), .rst_n(rst_n),
        .ext_hold_req_n(ext_hold_req_n), .ext_hold_ack_n(ext_hold_ack_n),
        .cpu_req(cpu_req), .cpu_gnt(cpu_gnt),
        .dma_req(dma_req), .dma_gnt(dma_gnt),
        .cyc_done(cyc_done),
        .rfsh_req(rfsh_req), .rfsh_gnt(rfsh_gnt), .rfsh_done(rfsh_done),
        .pin_drive_en(pin_drive_en), .strobe_park(strobe_park)
    );

    // Reference model: 0 idle, 1 cpu, 2 dma, 3 refresh, 4 park, 5 released
    int m_st = 0;
    bit m_s1 = 1'b1, m_s2 = 1'b1, m_pend = 1'b0, m_ack_n = 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_s1 = 1'b1; m_s2 = 1'b1; m_pend = 1'b0; m_ack_n = 1'b1;
        end else begin
            bit ereq;
            bit pend_old;
            int nst;
            ereq = !m_s2;
            pend_old = m_pend;
            nst = m_st;
            case (m_st)
                0: if (ereq) nst = 4; else if (pend_old) nst = 3;
                   else if (dma_req) nst = 2; else if (cpu_req) nst = 1;
                1, 2: if (cyc_done) nst = 0;
                3: if (rfsh_done) nst = 0;
                4: nst = 5;
                5: if (!ereq) nst = pend_old ? 3 : 0;
                default: nst = 0;
            endcase
            m_pend = rfsh_req || (pend_old && !(m_st == 3 && rfsh_done));
            m_ack_n = !(nst == 5 && !pend_old && !rfsh_req);
            m_s2 = m_s1;
            m_s1 = ext_hold_req_n;
            m_st = nst;
        end
    end

    task automatic cmp(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cmp("R5/R7/R9/R11 ack", ext_hold_ack_n, m_ack_n);
            cmp("R2/R3 cpu_gnt", cpu_gnt, m_st == 1);
            cmp("R2/R6 dma_gnt", dma_gnt, m_st == 2);
            cmp("R8/R10 rfsh_gnt", rfsh_gnt, m_st == 3);
            cmp("R4/R5 pin_drive_en", pin_drive_en, m_st != 5);
            cmp("R4/R5 strobe_park", strobe_park, m_st == 4);
        end
    end

    // Responder: bus cycles last three clocks, refresh lasts two
    int gcnt = 0, rcnt = 0;
    always @(negedge clk) begin
        if (cpu_gnt || dma_gnt) begin
            if (gcnt == 2) begin cyc_done = 1'b1; gcnt = 0; end
            else begin cyc_done = 1'b0; gcnt++; end
        end else begin
            cyc_done = 1'b0; gcnt = 0;
        end
        if (rfsh_gnt) begin
            if (rcnt == 1) begin rfsh_done = 1'b1; rcnt = 0; end
            else begin rfsh_done = 1'b0; rcnt++; end
        end else begin
            rfsh_done = force_done; rcnt = 0;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_refresh();
        @(negedge clk); rfsh_req = 1'b1;
        @(negedge clk); rfsh_req = 1'b0;
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        // R1: reset values
        step(3);
        cmp("R1 ack", ext_hold_ack_n, 1'b1);
        cmp("R1 cpu_gnt", cpu_gnt, 1'b0);
        cmp("R1 dma_gnt", dma_gnt, 1'b0);
        cmp("R1 rfsh_gnt", rfsh_gnt, 1'b0);
        cmp("R1 pin_drive_en", pin_drive_en, 1'b1);
        cmp("R1 strobe_park", strobe_park, 1'b0);
        rst_n = 1'b1;
        step(3);

        // R3: CPU alone
        cpu_req = 1'b1; step(12);
        // R2: DMA beats CPU
        dma_req = 1'b1; step(12);
        // R6: DMA burst preempted by external request; R4 two-flop latency
        ext_hold_req_n = 1'b0; step(12);
        ext_hold_req_n = 1'b1; step(8);

        // R7: refresh while released; R8: refresh before CPU/DMA on return
        ext_hold_req_n = 1'b0; step(10);
        pulse_refresh();
        step(6);
        ext_hold_req_n = 1'b1; step(10);

        // R9: refresh coincides with the park cycle
        dma_req = 1'b0; cpu_req = 1'b0; step(4);
        ext_hold_req_n = 1'b0;
        step(2);
        rfsh_req = 1'b1; step(1); rfsh_req = 1'b0;
        step(8);
        ext_hold_req_n = 1'b1; step(8);

        // R10: stray done outside refresh is ignored, pending survives
        ext_hold_req_n = 1'b0; step(6);
        pulse_refresh();
        force_done = 1'b1; step(3); force_done = 1'b0;
        ext_hold_req_n = 1'b1; step(10);

        // R2: refresh pending from idle wins over DMA
        dma_req = 1'b1; cpu_req = 1'b1;
        pulse_refresh();
        step(15);
        // R2: external + refresh together from idle
        dma_req = 1'b0; cpu_req = 1'b0; step(3);
        ext_hold_req_n = 1'b0; rfsh_req = 1'b1; step(1); rfsh_req = 1'b0;
        step(8);
        ext_hold_req_n = 1'b1; step(12);

        report();
    end
endmodule